// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the control half of a dynamically scheduled execution core with no register renaming. An instruction queue offers one decoded instruction per cycle: which functional unit it needs, one destination register and two source registers. The controller decides whether the instruction may enter a functional unit, when that unit may fetch its operands from the register file, and when it may drive its result back. Each instruction moves through four stages: issue, operand read, execution and write-back. Instructions enter in program order but may finish out of order.

Three kinds of conflict are resolved in three different places. A second writer of a register that already has one in flight is held at issue, and so is an instruction whose functional unit is occupied. A reader waits in the operand-read stage until every older producer of its sources has written back. A writer waits in the write-back stage while an older instruction still has to read the old value of its destination. Functional units are modelled as latency counters, with one latency parameter per unit. By default the units are an ALU (code 0, 1 cycle), a multiplier (code 1, 3 cycles) and a divider (code 2, 6 cycles), over 8 registers.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After synchronous reset, with `in_valid` low, `stall` is 0 and every bit of `read_go` and `write_go` is 0.
- R2: An instruction whose unit code (0 ALU, 1 multiplier, 2 divider) names a unit that holds an instruction is refused with `stall` high, from the cycle after that unit's issue up to and including its write-back cycle.
- R3: An instruction whose destination register is the destination of any instruction still in flight is refused with `stall` high, so no register ever has two pending writers.
- R4: At most one instruction is accepted per cycle, in queue order; it is accepted in any cycle where `in_valid` is high and `stall` is low, and `stall` is never high while `in_valid` is low.
- R5: A unit's `read_go` bit rises only once no older in-flight instruction targets either of its sources; if both sources are free at issue, `read_go` is high the cycle after issue.
- R6: An instruction accepted in the same cycle as the `write_go` of the producer of one of its sources treats that source as available, and can assert `read_go` the next cycle.
- R7: After `read_go` a unit executes for its latency L in cycles; `write_go` comes no sooner than L+1 cycles after `read_go`, and exactly then when no read is outstanding on its destination.
- R8: A unit waiting to write back is held while an older unit waiting for operands has a ready source equal to that destination; it writes the cycle after that reader's `read_go`.
- R9: A unit and its destination register both become free for a new issue in the cycle after the unit's `write_go`.
- R10: Write-back order follows readiness, not issue order: a short-latency instruction may write back before an older long-latency one.
- R11: For every accepted instruction, its unit pulses `read_go` for exactly one cycle and `write_go` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Queue head holds an instruction |
| in_unit | input | $clog2(NUM_FU) | Functional unit code of the head instruction |
| in_dst | input | $clog2(NUM_REGS) | Destination register |
| in_src1 | input | $clog2(NUM_REGS) | First source register |
| in_src2 | input | $clog2(NUM_REGS) | Second source register |
| stall | output | 1 | Head instruction is refused this cycle |
| read_go | output | NUM_FU | Per unit: fetch operands this cycle |
| write_go | output | NUM_FU | Per unit: drive result to the register file this cycle |

## Verification
The delicate coincidence is an issue landing in the same cycle as the write-back of the unit that produces one of its sources. The new entry must record that source as ready, or it would wait for a wake-up that has already passed. The bench provokes this by inserting idle cycles so that a consumer arrives exactly in its producer's write-back cycle, and by long random runs. A per-cycle reference model, which tracks instructions as an ordered list, predicts the following `read_go`, and a counter confirms that such early reads really happened. Read grant and write-back in the same cycle on the same register are judged the same way: the model expects the writer to be held for one cycle beyond the reader's grant.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // Life cycle of one functional-unit slot
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_RD = 2'd1,
        ST_EXEC    = 2'd2,
        ST_WAIT_WR = 2'd3
    } slot_state_e;

    // Latency below one is treated as one
    function automatic int unsigned min_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
    parameter int unsigned NUM_FU   = 3,
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned RIDX_W  = $clog2(NUM_REGS)
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 set_en,
    input  logic [RIDX_W-1:0]                    set_reg,
    input  logic [NUM_FU-1:0]                    set_prod,
    input  logic [NUM_FU-1:0]                    wb_vec,
    input  logic [NUM_FU-1:0][RIDX_W-1:0]        wb_dst,
    output logic [NUM_REGS-1:0]                  pend,
    output logic [NUM_REGS-1:0][NUM_FU-1:0]      prod
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            prod <= '0;
        end else begin
            for (int u = 0; u < NUM_FU; u++) begin
                if (wb_vec[u]) pend[wb_dst[u]] <= 1'b0;
            end
            if (set_en) begin
                pend[set_reg] <= 1'b1;
                prod[set_reg] <= set_prod;
            end
        end
    end

    // R3: a register is only claimed while it has no pending writer
    p_claim_free_r3: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !pend[set_reg]);

    generate
        for (genvar u = 0; u < NUM_FU; u++) begin : g_clr_chk
            // R9: register released the cycle after its write-back
            p_release_r9: assert property (@(posedge clk) disable iff (rst)
                wb_vec[u] |=> !pend[$past(wb_dst[u])]);
        end
    endgenerate

endmodule

// File: rtl/sb_unit_slot.sv
module sb_unit_slot
    import sb_pkg::*;
#(
    parameter int unsigned NUM_FU   = 3,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned LATENCY  = 1,
    localparam int unsigned RIDX_W  = $clog2(NUM_REGS),
    localparam int unsigned LAT_EFF = min_one(LATENCY),
    localparam int unsigned CNT_W   = $clog2(LAT_EFF + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  issue_en,
    input  logic [RIDX_W-1:0]     iss_dst,
    input  logic [RIDX_W-1:0]     iss_src1,
    input  logic [RIDX_W-1:0]     iss_src2,
    input  logic                  iss_wait1,
    input  logic                  iss_wait2,
    input  logic [NUM_FU-1:0]     iss_prod1,
    input  logic [NUM_FU-1:0]     iss_prod2,
    input  logic [NUM_FU-1:0]     wb_vec,
    input  logic [NUM_REGS-1:0]   rd_pending,
    output logic                  busy,
    output logic                  waiting_rd,
    output logic [RIDX_W-1:0]     dst,
    output logic [RIDX_W-1:0]     src1,
    output logic [RIDX_W-1:0]     src2,
    output logic                  rdy1,
    output logic                  rdy2,
    output logic                  read_go,
    output logic                  write_go
);

    slot_state_e          st_q;
    logic [NUM_FU-1:0]    prod1_q, prod2_q;
    logic [CNT_W-1:0]     cnt_q;

    assign busy       = (st_q != ST_IDLE);
    assign waiting_rd = (st_q == ST_WAIT_RD);
    assign read_go    = waiting_rd && rdy1 && rdy2;
    assign write_go   = (st_q == ST_WAIT_WR) && !rd_pending[dst];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            dst     <= '0;
            src1    <= '0;
            src2    <= '0;
            rdy1    <= 1'b0;
            rdy2    <= 1'b0;
            prod1_q <= '0;
            prod2_q <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (issue_en) begin
                    st_q    <= ST_WAIT_RD;
                    dst     <= iss_dst;
                    src1    <= iss_src1;
                    src2    <= iss_src2;
                    rdy1    <= !iss_wait1;
                    rdy2    <= !iss_wait2;
                    prod1_q <= iss_prod1;
                    prod2_q <= iss_prod2;
                end
                ST_WAIT_RD: begin
                    if (read_go) begin
                        st_q  <= ST_EXEC;
                        cnt_q <= CNT_W'(LAT_EFF - 1);
                        rdy1  <= 1'b0;
                        rdy2  <= 1'b0;
                    end else begin
                        if (!rdy1 && |(prod1_q & wb_vec)) rdy1 <= 1'b1;
                        if (!rdy2 && |(prod2_q & wb_vec)) rdy2 <= 1'b1;
                    end
                end
                ST_EXEC: begin
                    if (cnt_q == '0) st_q <= ST_WAIT_WR;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                ST_WAIT_WR: if (write_go) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R11: operand read is a single pulse
    p_read_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        read_go |=> !read_go);
    // R11: write-back is a single pulse
    p_write_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        write_go |=> !write_go);
    // R7: execution occupies at least one cycle between read and write
    p_exec_gap_r7: assert property (@(posedge clk) disable iff (rst)
        read_go |=> !write_go);
    // R9: slot is released right after write-back
    p_free_after_wb_r9: assert property (@(posedge clk) disable iff (rst)
        write_go |=> !busy);
    // R2: an occupied slot is never loaded again
    p_no_reload_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> !issue_en);

endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl #(
    parameter int unsigned NUM_FU           = 3,
    parameter int unsigned NUM_REGS         = 8,
    parameter int unsigned FU_LAT [NUM_FU]  = '{1, 3, 6},
    localparam int unsigned RIDX_W          = $clog2(NUM_REGS),
    localparam int unsigned UIDX_W          = $clog2(NUM_FU)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [UIDX_W-1:0]   in_unit,
    input  logic [RIDX_W-1:0]   in_dst,
    input  logic [RIDX_W-1:0]   in_src1,
    input  logic [RIDX_W-1:0]   in_src2,
    output logic                stall,
    output logic [NUM_FU-1:0]   read_go,
    output logic [NUM_FU-1:0]   write_go
);

    logic [NUM_FU-1:0]               unit_sel, issue_vec;
    logic [NUM_FU-1:0]               busy_vec, wait_vec, rdy1_vec, rdy2_vec;
    logic [NUM_FU-1:0][RIDX_W-1:0]   dst_a, s1_a, s2_a;
    logic [NUM_REGS-1:0]             reg_pend, rd_pending;
    logic [NUM_REGS-1:0][NUM_FU-1:0] reg_prod;
    logic                            accept, wait1, wait2;

    always_comb begin
        for (int u = 0; u < NUM_FU; u++) unit_sel[u] = (in_unit == UIDX_W'(u));
    end

    // Structural check, then WAW check on the destination
    assign accept    = in_valid && |(unit_sel & ~busy_vec) && !reg_pend[in_dst];
    assign stall     = in_valid && !accept;
    assign issue_vec = accept ? unit_sel : '0;

    // A source is pending unless its producer writes back this very cycle
    assign wait1 = reg_pend[in_src1] && !(|(reg_prod[in_src1] & write_go));
    assign wait2 = reg_pend[in_src2] && !(|(reg_prod[in_src2] & write_go));

    // Registers an older waiting reader still has to fetch (WAR guard)
    always_comb begin
        rd_pending = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (wait_vec[u] && rdy1_vec[u]) rd_pending[s1_a[u]] = 1'b1;
            if (wait_vec[u] && rdy2_vec[u]) rd_pending[s2_a[u]] = 1'b1;
        end
    end

    sb_reg_status #(.NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS)) u_regstat (
        .clk      (clk),
        .rst      (rst),
        .set_en   (accept),
        .set_reg  (in_dst),
        .set_prod (unit_sel),
        .wb_vec   (write_go),
        .wb_dst   (dst_a),
        .pend     (reg_pend),
        .prod     (reg_prod)
    );

    generate
        for (genvar u = 0; u < NUM_FU; u++) begin : g_slot
            sb_unit_slot #(
                .NUM_FU   (NUM_FU),
                .NUM_REGS (NUM_REGS),
                .LATENCY  (FU_LAT[u])
            ) u_slot (
                .clk        (clk),
                .rst        (rst),
                .issue_en   (issue_vec[u]),
                .iss_dst    (in_dst),
                .iss_src1   (in_src1),
                .iss_src2   (in_src2),
                .iss_wait1  (wait1),
                .iss_wait2  (wait2),
                .iss_prod1  (reg_prod[in_src1]),
                .iss_prod2  (reg_prod[in_src2]),
                .wb_vec     (write_go),
                .rd_pending (rd_pending),
                .busy       (busy_vec[u]),
                .waiting_rd (wait_vec[u]),
                .dst        (dst_a[u]),
                .src1       (s1_a[u]),
                .src2       (s2_a[u]),
                .rdy1       (rdy1_vec[u]),
                .rdy2       (rdy2_vec[u]),
                .read_go    (read_go[u]),
                .write_go   (write_go[u])
            );
        end

        for (genvar a = 0; a < NUM_FU; a++) begin : g_waw_a
            for (genvar b = a + 1; b < NUM_FU; b++) begin : g_waw_b
                // R3: two occupied units never share a destination
                p_single_writer_r3: assert property (@(posedge clk) disable iff (rst)
                    (busy_vec[a] && busy_vec[b]) |-> (dst_a[a] != dst_a[b]));
            end
        end
    endgenerate

    // R4: no refusal without an instruction
    p_idle_no_stall_r4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !stall);
    // R2: an accepted instruction occupies its unit next cycle
    p_accept_occupies_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !stall) |=> busy_vec[$past(in_unit)]);

endmodule

// File: tb/sb_hazard_ctrl_tb.sv
module sb_hazard_ctrl_tb_top;

    localparam int NFU = 3;
    localparam int NREG = 8;
    localparam int LAT [NFU] = '{1, 3, 6};

    typedef struct {
        bit v;
        int unit, dst, s1, s2;
    } stim_t;

    typedef struct {
        int unit, dst, s1, s2, stage, cnt;
        bit woke;
    } ent_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [1:0] in_unit = '0;
    logic [2:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic       stall;
    logic [NFU-1:0] read_go, write_go;

    int checks = 0, fails = 0;
    int issued = 0, rd_seen = 0, wr_seen = 0;
    int woke_reads = 0, war_holds = 0, ooo_writes = 0;
    bit done = 0;

    stim_t stim[$];
    ent_t  fl[$];

    always #5 clk = ~clk;

    sb_hazard_ctrl dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .stall(stall), .read_go(read_go), .write_go(write_go)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit src_ready(input int idx, input int r);
        for (int j = 0; j < idx; j++) if (fl[j].dst == r) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit war_blocked(input int d);
        for (int k = 0; k < fl.size(); k++) begin
            if (fl[k].stage == 0 &&
                ((fl[k].s1 == d && src_ready(k, fl[k].s1)) ||
                 (fl[k].s2 == d && src_ready(k, fl[k].s2)))) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic push(input int u, input int d, input int a, input int b);
        stim_t s;
        s.v = 1; s.unit = u; s.dst = d; s.s1 = a; s.s2 = b;
        stim.push_back(s);
    endtask

    task automatic gap(input int n);
        stim_t s;
        s.v = 0; s.unit = 0; s.dst = 0; s.s1 = 0; s.s2 = 0;
        for (int i = 0; i < n; i++) stim.push_back(s);
    endtask

    // One cycle: drive, predict, compare, advance the model
    task automatic step();
        stim_t cur;
        ent_t  e, nq[$];
        bit    busy_u[NFU], wr_u[NFU], erd[4], ewr[4];
        int    exp_rd[NFU], exp_wr[NFU];
        bit    dpend, dwrite, acc, exp_stall;
        string tag;

        @(negedge clk);
        if (stim.size() > 0) cur = stim[0];
        else begin cur.v = 0; cur.unit = 0; cur.dst = 0; cur.s1 = 0; cur.s2 = 0; end
        in_valid = cur.v;
        in_unit  = 2'(cur.unit);
        in_dst   = 3'(cur.dst);
        in_src1  = 3'(cur.s1);
        in_src2  = 3'(cur.s2);
        #1;

        for (int u = 0; u < NFU; u++) begin busy_u[u] = 0; wr_u[u] = 0; exp_rd[u] = 0; exp_wr[u] = 0; end
        dpend = 0; dwrite = 0;
        for (int i = 0; i < fl.size(); i++) begin
            erd[i] = (fl[i].stage == 0) && src_ready(i, fl[i].s1) && src_ready(i, fl[i].s2);
            ewr[i] = (fl[i].stage == 2) && !war_blocked(fl[i].dst);
            busy_u[fl[i].unit] = 1;
            if (ewr[i]) wr_u[fl[i].unit] = 1;
            if (erd[i]) exp_rd[fl[i].unit] = 1;
            if (ewr[i]) exp_wr[fl[i].unit] = 1;
            if (cur.v && fl[i].dst == cur.dst) begin dpend = 1; dwrite = ewr[i]; end
        end

        acc = cur.v && !busy_u[cur.unit] && !dpend;
        exp_stall = cur.v && !acc;
        if (!cur.v)                   tag = "R4";
        else if (busy_u[cur.unit])    tag = wr_u[cur.unit] ? "R9" : "R2";
        else if (dpend)               tag = dwrite ? "R9" : "R3";
        else                          tag = "R4";
        chk(tag, stall, exp_stall, "stall");

        for (int u = 0; u < NFU; u++) begin
            tag = busy_u[u] ? "R5" : "R11";
            for (int i = 0; i < fl.size(); i++)
                if (fl[i].unit == u && fl[i].stage == 0 && fl[i].woke) tag = "R6";
            chk(tag, read_go[u], exp_rd[u], $sformatf("read_go[%0d]", u));
            tag = busy_u[u] ? "R7" : "R11";
            for (int i = 0; i < fl.size(); i++)
                if (fl[i].unit == u && fl[i].stage == 2 && !ewr[i]) begin
                    tag = "R8";
                    if (!write_go[u]) war_holds++;
                end
            chk(tag, write_go[u], exp_wr[u], $sformatf("write_go[%0d]", u));
            if (read_go[u]) rd_seen++;
            if (write_go[u]) wr_seen++;
        end

        for (int i = 0; i < fl.size(); i++) begin
            if (erd[i] && fl[i].woke && read_go[fl[i].unit]) woke_reads++;
            if (ewr[i] && i > 0 && write_go[fl[i].unit]) ooo_writes++;
        end

        nq = {};
        for (int i = 0; i < fl.size(); i++) begin
            e = fl[i];
            if (!(e.stage == 2 && ewr[i])) begin
                if (e.stage == 0 && erd[i]) begin e.stage = 1; e.cnt = LAT[e.unit] - 1; end
                else if (e.stage == 1) begin
                    if (e.cnt == 0) e.stage = 2; else e.cnt--;
                end
                e.woke = 0;
                nq.push_back(e);
            end
        end
        if (acc) begin
            e.unit = cur.unit; e.dst = cur.dst; e.s1 = cur.s1; e.s2 = cur.s2;
            e.stage = 0; e.cnt = 0; e.woke = 0;
            for (int i = 0; i < fl.size(); i++)
                if (ewr[i] && (fl[i].dst == cur.s1 || fl[i].dst == cur.s2)) e.woke = 1;
            nq.push_back(e);
            issued++;
        end
        fl = nq;
        if (stim.size() > 0 && (!cur.v || acc)) void'(stim.pop_front());
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd11);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: idle after reset
        chk("R1", stall, 0, "stall after reset");
        chk("R1", read_go, 0, "read_go after reset");
        chk("R1", write_go, 0, "write_go after reset");

        gap(1);
        push(2, 1, 6, 7);   // long divide into r1
        push(0, 2, 3, 4);   // ALU finishes first (R10)
        push(0, 4, 1, 1);   // RAW on r1, structural on ALU
        gap(14);
        push(2, 1, 6, 6);   // divide into r1
        push(0, 2, 1, 7);   // waits on r1, r7 ready
        push(1, 7, 3, 3);   // r7 writer held by WAR (R8)
        gap(14);
        push(2, 0, 1, 2);
        push(0, 0, 3, 3);   // WAW on r0 (R3)
        gap(14);
        push(0, 3, 5, 5);   // ALU r3: issue t, read t+1, exec t+2, write t+3
        gap(2);
        push(1, 5, 3, 3);   // arrives in producer's write-back cycle (R6)
        gap(10);
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 4) == 0) gap(1);
            else push($urandom_range(0, 2), $urandom_range(0, 7),
                      $urandom_range(0, 7), $urandom_range(0, 7));
        end

        for (int c = 0; c < 20000 && (stim.size() > 0 || fl.size() > 0); c++) step();
        repeat (3) step();

        chk("R11", rd_seen, issued, "read pulses per instruction");
        chk("R11", wr_seen, issued, "write pulses per instruction");
        chk("R10", ooo_writes > 0, 1, "out-of-order write-back observed");
        chk("R6", woke_reads > 0, 1, "read after same-cycle issue wake");
        chk("R8", war_holds > 0, 1, "write-back held by pending read");
        chk("R4", stim.size(), 0, "queue drained");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule